// File: doc/BRIEF.md
# CAN Bit Timing Quantum Generator

This block turns the protocol clock into the time base of one CAN-style bit. A programmable divider makes a time-quantum tick from the clock. Each nominal bit is then built from quanta in a fixed order: one synchronisation quantum, a programmable first phase segment and a programmable second phase segment. The block marks the sample point with a strobe at the end of the first segment. It marks the bit boundary with a strobe at the end of the second segment. It also shows which segment is in progress.

The divider and segment settings are captured only while the controller holds the block in initialization mode. Outside that mode the captured settings are frozen and the timing runs. If the captured settings are not allowed, the block reports a configuration error and keeps all counters idle. Edge resynchronisation and hard sync are done by the bit-stream logic around this block.

Top module: `can_bt_gen`

## Requirements
- R1: While running, `tq_tick` pulses for one cycle every `brp_code + 1` clock cycles. `brp_code` is 6 bits, so the quantum is 1 to 64 clocks.
- R2: While running, consecutive `bit_end` pulses are `(brp_code+1) * (ts1_code + ts2_code + 3)` cycles apart. That is 1 sync quantum, `ts1_code+1` quanta for segment 1 and `ts2_code+1` quanta for segment 2.
- R3: `sample_pt` is a one-cycle pulse at the end of the last quantum of segment 1. It follows the previous bit boundary by `(brp_code+1) * (ts1_code+2)` cycles.
- R4: `seg` encodes the current segment as 00 idle, 01 sync, 10 segment 1 and 11 segment 2. It reads 11 in the cycle of a `sample_pt` pulse and 01 in the cycle of a `bit_end` pulse, because both strobes are registered together with the segment change.
- R5: A captured setting with `ts1_code` below 3 (segment 1 under 4 quanta) or `ts2_code` equal to 0 (segment 2 under 2 quanta) sets `cfg_err`. While `cfg_err` is set, `seg` stays 00 and no `tq_tick`, `sample_pt` or `bit_end` pulse occurs.
- R6: Setting inputs are captured only in cycles where `init_mode` is 1. Changes to them while `init_mode` is 0 have no effect on any output.
- R7: While `init_mode` is 1, `seg` is 00 and no strobe is issued. With a legal setting, the first `bit_end` after `init_mode` falls is registered `(brp_code+1) * (ts1_code+ts2_code+3)` clocks after the first edge that sees `init_mode` low. The first `tq_tick` comes `brp_code+1` clocks after that edge.
- R8: While `rst` is high, all outputs are 0 and the captured setting is the legal default: a quantum of 1 clock, 4 quanta for segment 1 and 2 quanta for segment 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Protocol clock |
| rst | input | 1 | Synchronous active-high reset |
| init_mode | input | 1 | Initialization mode: captures settings and holds timing idle |
| brp_code | input | 6 | Quantum prescaler, value minus one |
| ts1_code | input | 4 | Segment 1 length in quanta, minus one |
| ts2_code | input | 3 | Segment 2 length in quanta, minus one |
| tq_tick | output | 1 | One-cycle pulse at the end of every time quantum |
| sample_pt | output | 1 | One-cycle pulse at the end of segment 1 |
| bit_end | output | 1 | One-cycle pulse at the end of segment 2 |
| seg | output | 2 | Current segment: 00 idle, 01 sync, 10 segment 1, 11 segment 2 |
| cfg_err | output | 1 | Captured setting is illegal |

## Verification
The assertions check on every cycle the structural rules: the settings are frozen outside initialization mode, the prescaler and quantum counters never pass their captured limits, the strobes line up with the segment code and with each other, and an illegal setting keeps the timing idle. The exact cycle distances cannot be seen by a single property. These are the tick spacing, the bit length, the sample-point position and the start-up latency after initialization. The bench measures them over every legal segment combination at small prescaler values and at the largest prescaler. It also covers the illegal codes and the frozen-settings case.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;
  typedef enum logic [1:0] {
    SEG_IDLE = 2'b00,
    SEG_SYNC = 2'b01,
    SEG_PH1  = 2'b10,
    SEG_PH2  = 2'b11
  } seg_e;
endpackage

// File: rtl/can_bt_cfg.sv
module can_bt_cfg #(
  parameter int BRP_W   = 6,
  parameter int TS1_W   = 4,
  parameter int TS2_W   = 3,
  parameter int MIN_TS1 = 4,
  parameter int MIN_TS2 = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             init_mode,
  input  logic [BRP_W-1:0] brp_in,
  input  logic [TS1_W-1:0] ts1_in,
  input  logic [TS2_W-1:0] ts2_in,
  output logic [BRP_W-1:0] brp_q,
  output logic [TS1_W-1:0] ts1_q,
  output logic [TS2_W-1:0] ts2_q,
  output logic             legal,
  output logic             cfg_err
);
  localparam logic [TS1_W-1:0] TS1_LO = TS1_W'(MIN_TS1 - 1);
  localparam logic [TS2_W-1:0] TS2_LO = TS2_W'(MIN_TS2 - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      brp_q <= '0;
      ts1_q <= TS1_LO;
      ts2_q <= TS2_LO;
    end else if (init_mode) begin
      brp_q <= brp_in;
      ts1_q <= ts1_in;
      ts2_q <= ts2_in;
    end
  end

  assign legal = (ts1_q >= TS1_LO) && (ts2_q >= TS2_LO);

  always_ff @(posedge clk) begin
    if (rst) cfg_err <= 1'b0;
    else     cfg_err <= ~legal;
  end

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !init_mode |=> $stable({brp_q, ts1_q, ts2_q})); // R6
endmodule

// File: rtl/can_bt_presc.sv
module can_bt_presc #(
  parameter int BRP_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [BRP_W-1:0] brp_q,
  output logic             tick
);
  logic [BRP_W-1:0] pre_cnt;

  assign tick = enable && (pre_cnt == brp_q);

  always_ff @(posedge clk) begin
    if (rst || !enable) pre_cnt <= '0;
    else if (tick)      pre_cnt <= '0;
    else                pre_cnt <= pre_cnt + 1'b1;
  end

  AST_PRESC_BOUND: assert property (@(posedge clk) disable iff (rst)
    pre_cnt <= brp_q); // R1
endmodule

// File: rtl/can_bt_seq.sv
module can_bt_seq
  import can_bt_pkg::*;
#(
  parameter int TS1_W = 4,
  parameter int TS2_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic             tick,
  input  logic [TS1_W-1:0] ts1_q,
  input  logic [TS2_W-1:0] ts2_q,
  output seg_e             seg,
  output logic             tq_out,
  output logic             sample_pt,
  output logic             bit_end
);
  localparam int CNT_W = (TS1_W > TS2_W) ? TS1_W : TS2_W;

  logic [CNT_W-1:0] q_cnt;
  logic             last_ph1;
  logic             last_ph2;

  assign last_ph1 = (seg == SEG_PH1) && (q_cnt == CNT_W'(ts1_q));
  assign last_ph2 = (seg == SEG_PH2) && (q_cnt == CNT_W'(ts2_q));

  always_ff @(posedge clk) begin
    if (rst || !go) begin
      seg       <= SEG_IDLE;
      q_cnt     <= '0;
      tq_out    <= 1'b0;
      sample_pt <= 1'b0;
      bit_end   <= 1'b0;
    end else begin
      tq_out    <= tick;
      sample_pt <= tick && last_ph1;
      bit_end   <= tick && last_ph2;
      if (seg == SEG_IDLE) begin
        seg   <= SEG_SYNC;
        q_cnt <= '0;
      end else if (tick) begin
        unique case (seg)
          SEG_SYNC: begin
            seg   <= SEG_PH1;
            q_cnt <= '0;
          end
          SEG_PH1: begin
            if (last_ph1) begin
              seg   <= SEG_PH2;
              q_cnt <= '0;
            end else begin
              q_cnt <= q_cnt + 1'b1;
            end
          end
          SEG_PH2: begin
            if (last_ph2) begin
              seg   <= SEG_SYNC;
              q_cnt <= '0;
            end else begin
              q_cnt <= q_cnt + 1'b1;
            end
          end
          default: seg <= SEG_IDLE;
        endcase
      end
    end
  end

  AST_SAMPLE_IN_PH2: assert property (@(posedge clk) disable iff (rst)
    sample_pt |-> seg == SEG_PH2); // R4
  AST_END_IN_SYNC: assert property (@(posedge clk) disable iff (rst)
    bit_end |-> seg == SEG_SYNC); // R4
  AST_STROBES_APART: assert property (@(posedge clk) disable iff (rst)
    !(sample_pt && bit_end)); // R3
  AST_PH1_BOUND: assert property (@(posedge clk) disable iff (rst)
    (seg == SEG_PH1) |-> q_cnt <= CNT_W'(ts1_q)); // R3
  AST_PH2_BOUND: assert property (@(posedge clk) disable iff (rst)
    (seg == SEG_PH2) |-> q_cnt <= CNT_W'(ts2_q)); // R2
  AST_IDLE_WHEN_STOPPED: assert property (@(posedge clk) disable iff (rst)
    !go |=> seg == SEG_IDLE && !tq_out); // R7
endmodule

// File: rtl/can_bt_gen.sv
module can_bt_gen
  import can_bt_pkg::*;
#(
  parameter int BRP_W   = 6,
  parameter int TS1_W   = 4,
  parameter int TS2_W   = 3,
  parameter int MIN_TS1 = 4,
  parameter int MIN_TS2 = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             init_mode,
  input  logic [BRP_W-1:0] brp_code,
  input  logic [TS1_W-1:0] ts1_code,
  input  logic [TS2_W-1:0] ts2_code,
  output logic             tq_tick,
  output logic             sample_pt,
  output logic             bit_end,
  output logic [1:0]       seg,
  output logic             cfg_err
);
  logic [BRP_W-1:0] brp_q;
  logic [TS1_W-1:0] ts1_q;
  logic [TS2_W-1:0] ts2_q;
  logic             legal;
  logic             go;
  logic             tick;
  seg_e             seg_s;

  assign go = ~init_mode & legal;

  can_bt_cfg #(
    .BRP_W(BRP_W), .TS1_W(TS1_W), .TS2_W(TS2_W),
    .MIN_TS1(MIN_TS1), .MIN_TS2(MIN_TS2)
  ) cfg_i (
    .clk(clk), .rst(rst), .init_mode(init_mode),
    .brp_in(brp_code), .ts1_in(ts1_code), .ts2_in(ts2_code),
    .brp_q(brp_q), .ts1_q(ts1_q), .ts2_q(ts2_q),
    .legal(legal), .cfg_err(cfg_err)
  );

  can_bt_presc #(.BRP_W(BRP_W)) presc_i (
    .clk(clk), .rst(rst),
    .enable(go && (seg_s != SEG_IDLE)),
    .brp_q(brp_q), .tick(tick)
  );

  can_bt_seq #(.TS1_W(TS1_W), .TS2_W(TS2_W)) seq_i (
    .clk(clk), .rst(rst), .go(go), .tick(tick),
    .ts1_q(ts1_q), .ts2_q(ts2_q),
    .seg(seg_s), .tq_out(tq_tick),
    .sample_pt(sample_pt), .bit_end(bit_end)
  );

  assign seg = seg_s;

  AST_ERR_HOLDS_IDLE: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> (seg == 2'b00) && !tq_tick && !sample_pt && !bit_end); // R5
  AST_END_ON_QUANTUM: assert property (@(posedge clk) disable iff (rst)
    bit_end |-> tq_tick); // R2
endmodule

// File: tb/can_bt_gen_tb.sv
module can_bt_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       init_mode = 1'b1;
  logic [5:0] brp_code = '0;
  logic [3:0] ts1_code = 4'd3;
  logic [2:0] ts2_code = 3'd1;
  logic       tq_tick, sample_pt, bit_end, cfg_err;
  logic [1:0] seg;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  can_bt_gen dut_i (
    .clk(clk), .rst(rst), .init_mode(init_mode),
    .brp_code(brp_code), .ts1_code(ts1_code), .ts2_code(ts2_code),
    .tq_tick(tq_tick), .sample_pt(sample_pt), .bit_end(bit_end),
    .seg(seg), .cfg_err(cfg_err)
  );

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Capture a setting in init mode, verify the idle state and the error flag.
  task automatic load_cfg(int b, int t1, int t2);
    @(negedge clk);
    init_mode = 1'b1;
    brp_code  = 6'(b);
    ts1_code  = 4'(t1);
    ts2_code  = 3'(t2);
    repeat (3) @(negedge clk);
    check(seg == 2'b00 && !tq_tick && !sample_pt && !bit_end, "R7 idle in init",
          int'(seg), 0);
    check(cfg_err == ((t1 < 3) || (t2 < 1)), "R5 cfg_err flag",
          int'(cfg_err), int'((t1 < 3) || (t2 < 1)));
  endtask

  // Called at a negedge right after init_mode was dropped.
  task automatic measure(int p, int t1, int t2);
    int n = p * (t1 + t2 + 3);
    int be1 = -1, be2 = -1, sp = -1, tq1 = -1, tq2 = -1;
    bit segbad = 1'b0;
    for (int k = 1; k <= 2 * n + 2; k++) begin
      @(negedge clk);
      if (bit_end) begin
        if (be1 < 0) be1 = k;
        else if (be2 < 0) be2 = k;
        if (seg != 2'b01) segbad = 1'b1;
      end
      if (sample_pt) begin
        if (sp < 0) sp = k;
        if (seg != 2'b11) segbad = 1'b1;
      end
      if (tq_tick) begin
        if (tq1 < 0) tq1 = k;
        else if (tq2 < 0) tq2 = k;
      end
    end
    check(tq1 == p + 1, "R7 first tq_tick", tq1, p + 1);
    check(tq2 - tq1 == p, "R1 tq period", tq2 - tq1, p);
    check(be1 == n + 1, "R7 first bit_end", be1, n + 1);
    check(be2 - be1 == n, "R2 bit length", be2 - be1, n);
    check(sp == p * (t1 + 2) + 1, "R3 sample point", sp, p * (t1 + 2) + 1);
    check(!segbad, "R4 seg at strobes", int'(segbad), 0);
  endtask

  task automatic run_legal(int b, int t1, int t2);
    load_cfg(b, t1, t2);
    init_mode = 1'b0;
    measure(b + 1, t1, t2);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(seg == 2'b00 && !tq_tick && !sample_pt && !bit_end && !cfg_err,
          "R8 reset outputs", int'({seg, tq_tick, sample_pt, bit_end, cfg_err}), 0);
    rst = 1'b0;
    // Reset default setting: quantum 1, segment 1 = 4, segment 2 = 2.
    init_mode = 1'b0;
    measure(1, 3, 1);

    // Sweep every legal segment pair at small prescalers.
    for (int b = 0; b <= 2; b++)
      for (int t1 = 3; t1 <= 15; t1++)
        for (int t2 = 1; t2 <= 7; t2++)
          run_legal(b, t1, t2);

    // Largest prescaler at the segment extremes.
    run_legal(63, 3, 1);
    run_legal(63, 15, 7);

    // Illegal codes: segment 1 under 4 quanta or segment 2 under 2 quanta.
    for (int i = 0; i < 4; i++) begin
      bit quiet = 1'b1;
      int t1 = (i < 3) ? i : 8;
      int t2 = (i < 3) ? 4 : 0;
      load_cfg(1, t1, t2);
      init_mode = 1'b0;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (seg != 2'b00 || tq_tick || sample_pt || bit_end || !cfg_err) quiet = 1'b0;
      end
      check(quiet, "R5 illegal holds idle", int'(quiet), 1);
    end

    // Inputs changed outside init mode must not alter timing.
    load_cfg(1, 5, 2);
    init_mode = 1'b0;
    brp_code  = 6'd4;
    ts1_code  = 4'd0;
    ts2_code  = 3'd0;
    measure(2, 5, 2);
    check(!cfg_err, "R6 no error from ignored codes", int'(cfg_err), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule